// File: doc/BRIEF.md
# Receive FIFO Occupancy Status Word

This block watches a byte-counted receive packet buffer and turns its state into a 64-bit status word that host software reads after asking for a receive copy. Some fields are live and are rebuilt every cycle from the buffer: the number of packets not yet handed to a reader, an empty indication, and an indication that the byte occupancy is above a programmable high mark. Other fields are held state that changes only at copy events: busy, complete, more-data-remaining, and a sticky "low" flag.

The low flag uses hysteresis between two programmable byte marks. When a copy finishes, the flag is set if occupancy is under the low mark and cleared if occupancy is over the high mark. In every other cycle it keeps its value. Software can read this flag to learn whether the buffer has drained since it last filled up. Recommended mark values are 393216 bytes for high and 131072 bytes for low. When a finishing copy leaves the buffer empty, the block also raises a one-cycle empty-interrupt pulse. The buffer storage, the DMA engine and the register bus are not part of this block.

Top module: `rx_occ_status`

## Requirements
- R1: While reset is asserted and after it is released, the low flag (bit 26) is 1 and busy, complete, more (bits 31, 30, 29) and `empty_irq` are 0.
- R2: Bits 47:32 carry `pend_pkts` combinationally, the packets not yet assigned to a reader.
- R3: Bit 28 equals `fifo_empty` combinationally.
- R4: Bit 27 is 1 exactly when `fifo_occ` is strictly greater than `high_mark`, compared as unsigned numbers.
- R5: On a cycle with `copy_done` high, if `fifo_occ` is strictly less than `low_mark` and not above `high_mark`, the low flag becomes 1 from the next cycle.
- R6: On a cycle with `copy_done` high, if `fifo_occ` is strictly greater than `high_mark`, the low flag becomes 0 from the next cycle. This clearing wins even when the marks are set the wrong way round. Occupancy equal to either mark leaves the flag unchanged.
- R7: In a cycle without `copy_done`, the low flag keeps its value whatever the occupancy is.
- R8: `copy_start` makes bit 31 equal 1 and bits 30 and 29 equal 0 from the next cycle.
- R9: `copy_done` without `copy_start` makes bit 31 equal 0 and bit 30 equal 1, and sets bit 29 to `copy_more`, from the next cycle.
- R10: `empty_irq` is 1 for exactly the one cycle after a cycle in which `copy_done` and `fifo_empty` are both high. It is 0 in every other cycle.
- R11: Bits 63:48 and bits 25:0 of the status word are always 0.
- R12: When `copy_start` and `copy_done` are high in the same cycle, the start wins for bits 31 to 29. The low flag and `empty_irq` still respond to the done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_occ | input | OCC_W (32) | Receive buffer occupancy in bytes |
| fifo_empty | input | 1 | Receive buffer holds no packets |
| pend_pkts | input | PKT_W (16) | Packets not yet assigned to a reader |
| high_mark | input | OCC_W (32) | High byte mark |
| low_mark | input | OCC_W (32) | Low byte mark |
| copy_start | input | 1 | Receive copy request accepted (one cycle) |
| copy_done | input | 1 | Receive copy finished (one cycle) |
| copy_more | input | 1 | Qualifies `copy_done`: the packet still has data left |
| status_word | output | 64 | Packed status word |
| empty_irq | output | 1 | One-cycle pulse: the finishing copy left the buffer empty |

## Verification
If the hysteresis state is wrong, bit 26 shows it in the first cycle after the copy-done that should have moved it. The flag then stays wrong until a later copy-done happens with occupancy outside the two marks, so a single bad update can stay visible for many reads. Errors in the live fields (occupancy comparison, empty, packet count) appear in the same cycle as the input that causes them. A wrong busy/complete/more register shows one cycle after the start or done event. Bench sweeps compare every field after every step against a model built only from the requirements, so any of these errors shows up at the next sample.

// File: rtl/rxo_pkg.sv
package rxo_pkg;

    localparam int WORD_W    = 64;
    localparam int PKT_LSB   = 32;
    localparam int PKT_FLD_W = 16;
    localparam int BUSY_BIT  = 31;
    localparam int CMPL_BIT  = 30;
    localparam int MORE_BIT  = 29;
    localparam int EMPTY_BIT = 28;
    localparam int HIGH_BIT  = 27;
    localparam int LOW_BIT   = 26;

    typedef struct packed {
        logic low;
        logic busy;
        logic cmpl;
        logic more;
        logic empty_irq;
    } trk_t;

    localparam trk_t TRK_RST = '{low: 1'b1, busy: 1'b0, cmpl: 1'b0,
                                 more: 1'b0, empty_irq: 1'b0};

endpackage

// File: rtl/rxo_mark_cmp.sv
module rxo_mark_cmp #(
    parameter int W = 32
) (
    input  logic [W-1:0] occ,
    input  logic [W-1:0] high_mark,
    input  logic [W-1:0] low_mark,
    output logic         above_high,
    output logic         below_low
);
    // Both comparisons are unsigned byte counts.
    always_comb begin
        above_high = (occ > high_mark);
        below_low  = (occ < low_mark);
    end
endmodule

// File: rtl/rxo_track.sv
module rxo_track
    import rxo_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic copy_start,
    input  logic copy_done,
    input  logic copy_more,
    input  logic fifo_empty,
    input  logic above_high,
    input  logic below_low,
    output trk_t trk_q
);
    trk_t trk_d;

    always_comb begin
        trk_d           = trk_q;
        trk_d.empty_irq = 1'b0;
        if (copy_done) begin
            // Clearing on the high side has priority over setting.
            if (above_high)
                trk_d.low = 1'b0;
            else if (below_low)
                trk_d.low = 1'b1;
            trk_d.empty_irq = fifo_empty;
        end
        if (copy_start) begin
            trk_d.busy = 1'b1;
            trk_d.cmpl = 1'b0;
            trk_d.more = 1'b0;
        end else if (copy_done) begin
            trk_d.busy = 1'b0;
            trk_d.cmpl = 1'b1;
            trk_d.more = copy_more;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            trk_q <= TRK_RST;
        else
            trk_q <= trk_d;
    end

    // R7: the flag only moves at a copy completion
    a_r7_low_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !copy_done |=> $stable(trk_q.low));

    // R6: an over-mark completion always clears the flag
    a_r6_high_clears: assert property (@(posedge clk) disable iff (!rst_n)
        copy_done && above_high |=> !trk_q.low);

    // R8/R9: busy and complete are never seen together
    a_r9_busy_cmpl_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({trk_q.busy, trk_q.cmpl}));

    // R10: the pulse is always caused by an emptying completion
    a_r10_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        trk_q.empty_irq |-> $past(copy_done && fifo_empty));

    // R12: a start wins over a simultaneous done
    a_r12_start_wins: assert property (@(posedge clk) disable iff (!rst_n)
        copy_start |=> trk_q.busy && !trk_q.cmpl);
endmodule

// File: rtl/rxo_pack.sv
module rxo_pack
    import rxo_pkg::*;
#(
    parameter int PKT_W = 16
) (
    input  logic [PKT_W-1:0]  pend,
    input  trk_t              trk,
    input  logic              fifo_empty,
    input  logic              above_high,
    output logic [WORD_W-1:0] word
);
    logic [PKT_FLD_W-1:0] pkt_fld;

    generate
        if (PKT_W > PKT_FLD_W) begin : g_sat
            // Wider counter than the field: saturate.
            always_comb begin
                if (|pend[PKT_W-1:PKT_FLD_W])
                    pkt_fld = '1;
                else
                    pkt_fld = pend[PKT_FLD_W-1:0];
            end
        end else begin : g_ext
            always_comb pkt_fld = PKT_FLD_W'(pend);
        end
    endgenerate

    always_comb begin
        word                          = '0;
        word[PKT_LSB +: PKT_FLD_W]    = pkt_fld;
        word[BUSY_BIT]                = trk.busy;
        word[CMPL_BIT]                = trk.cmpl;
        word[MORE_BIT]                = trk.more;
        word[EMPTY_BIT]               = fifo_empty;
        word[HIGH_BIT]                = above_high;
        word[LOW_BIT]                 = trk.low;
    end
endmodule

// File: rtl/rx_occ_status.sv
module rx_occ_status
    import rxo_pkg::*;
#(
    parameter int OCC_W = 32,
    parameter int PKT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OCC_W-1:0]  fifo_occ,
    input  logic              fifo_empty,
    input  logic [PKT_W-1:0]  pend_pkts,
    input  logic [OCC_W-1:0]  high_mark,
    input  logic [OCC_W-1:0]  low_mark,
    input  logic              copy_start,
    input  logic              copy_done,
    input  logic              copy_more,
    output logic [WORD_W-1:0] status_word,
    output logic              empty_irq
);
    logic above_high;
    logic below_low;
    trk_t trk_q;

    rxo_mark_cmp #(.W(OCC_W)) u_cmp (
        .occ        (fifo_occ),
        .high_mark  (high_mark),
        .low_mark   (low_mark),
        .above_high (above_high),
        .below_low  (below_low)
    );

    rxo_track u_trk (
        .clk        (clk),
        .rst_n      (rst_n),
        .copy_start (copy_start),
        .copy_done  (copy_done),
        .copy_more  (copy_more),
        .fifo_empty (fifo_empty),
        .above_high (above_high),
        .below_low  (below_low),
        .trk_q      (trk_q)
    );

    rxo_pack #(.PKT_W(PKT_W)) u_pack (
        .pend       (pend_pkts),
        .trk        (trk_q),
        .fifo_empty (fifo_empty),
        .above_high (above_high),
        .word       (status_word)
    );

    assign empty_irq = trk_q.empty_irq;

    // R4: the high bit in the word agrees with the raw ports
    a_r4_high_bit: assert property (@(posedge clk) disable iff (!rst_n)
        status_word[HIGH_BIT] == (fifo_occ > high_mark));

    // R5: an under-mark completion (not above high) sets the flag
    a_r5_low_sets: assert property (@(posedge clk) disable iff (!rst_n)
        copy_done && (fifo_occ < low_mark) && !(fifo_occ > high_mark)
        |=> status_word[LOW_BIT]);
endmodule

// File: tb/rx_occ_status_tb.sv
`timescale 1ns/1ps
module rx_occ_status_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] fifo_occ;
    logic        fifo_empty;
    logic [15:0] pend_pkts;
    logic [31:0] high_mark, low_mark;
    logic        copy_start, copy_done, copy_more;
    logic [63:0] status_word;
    logic        empty_irq;

    int n_run  = 0;
    int n_fail = 0;
    bit done_flag = 0;

    // model state
    bit m_low, m_busy, m_cmpl, m_more, m_irq;

    always #2 clk = ~clk;

    rx_occ_status u_dut (
        .clk(clk), .rst_n(rst_n), .fifo_occ(fifo_occ), .fifo_empty(fifo_empty),
        .pend_pkts(pend_pkts), .high_mark(high_mark), .low_mark(low_mark),
        .copy_start(copy_start), .copy_done(copy_done), .copy_more(copy_more),
        .status_word(status_word), .empty_irq(empty_irq)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_all();
        logic [63:0] w = status_word;
        chk("R2 pkt field", {48'd0, w[47:32]}, {48'd0, pend_pkts});
        chk("R3 empty bit", {63'd0, w[28]}, {63'd0, fifo_empty});
        chk("R4 high bit", {63'd0, w[27]}, {63'd0, (fifo_occ > high_mark)});
        chk("R5/R6/R7 low flag", {63'd0, w[26]}, {63'd0, m_low});
        chk("R8/R9/R12 busy cmpl more", {61'd0, w[31:29]}, {61'd0, m_busy, m_cmpl, m_more});
        chk("R10 empty irq", {63'd0, empty_irq}, {63'd0, m_irq});
        chk("R11 reserved zero", {w[63:48], 22'd0, w[25:0]}, 64'd0);
    endtask

    // drive one cycle of stimulus, update model, check after the edge
    task automatic step(input logic [31:0] occ, input bit emp, input logic [15:0] pend,
                        input bit st, input bit dn, input bit mr);
        @(negedge clk);
        fifo_occ = occ; fifo_empty = emp; pend_pkts = pend;
        copy_start = st; copy_done = dn; copy_more = mr;
        // model from the requirements
        m_irq = dn && emp;
        if (dn) begin
            if (occ > high_mark) m_low = 0;
            else if (occ < low_mark) m_low = 1;
        end
        if (st) begin m_busy = 1; m_cmpl = 0; m_more = 0; end
        else if (dn) begin m_busy = 0; m_cmpl = 1; m_more = mr; end
        @(posedge clk);
        @(negedge clk);
        copy_start = 0; copy_done = 0; copy_more = 0;
        #0.5;
        check_all();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 0; fifo_occ = 0; fifo_empty = 1; pend_pkts = 0;
        high_mark = 32'd40; low_mark = 32'd20;
        copy_start = 0; copy_done = 0; copy_more = 0;
        m_low = 1; m_busy = 0; m_cmpl = 0; m_more = 0; m_irq = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset values during reset
        chk("R1 reset word", status_word, 64'h0000_0000_1400_0000);
        chk("R1 reset irq", {63'd0, empty_irq}, 64'd0);
        rst_n = 1;
        @(negedge clk);
        chk("R1 after release", status_word, 64'h0000_0000_1400_0000);

        // Sweep with small marks: occupancy 0..63 in a scrambled order
        for (int i = 0; i < 256; i++) begin
            logic [31:0] o = 32'((i * 37) % 64);
            step(o, (o == 0), 16'(i % 23), (i % 5 == 0), (i % 3 != 0), i[0]);
        end

        // R6: equality with either mark holds the flag
        step(32'd50, 0, 16'd1, 0, 1, 0);   // clears
        step(32'd40, 0, 16'd1, 0, 1, 0);   // equal high: hold 0
        step(32'd20, 0, 16'd1, 0, 1, 0);   // equal low: hold 0
        step(32'd19, 0, 16'd1, 0, 1, 0);   // R5 sets
        step(32'd40, 0, 16'd1, 0, 1, 0);   // hold 1
        // R7: no completion, occupancy far above high
        step(32'd60, 0, 16'd2, 0, 0, 0);
        chk("R7 held without done", {63'd0, status_word[26]}, 64'd1);

        // R12: start and done together
        step(32'd5, 1, 16'd0, 1, 1, 1);
        chk("R12 start wins", {61'd0, status_word[31:29]}, 64'd4);
        chk("R10 irq on simultaneous done", {63'd0, empty_irq}, 64'd1);
        step(32'd5, 1, 16'd0, 0, 0, 0);
        chk("R10 single cycle pulse", {63'd0, empty_irq}, 64'd0);

        // R6: marks the wrong way round, clearing wins
        high_mark = 32'd10; low_mark = 32'd50;
        step(32'd30, 0, 16'd3, 0, 1, 1);
        chk("R6 inverted marks clear", {63'd0, status_word[26]}, 64'd0);

        // Recommended marks, boundaries and unsigned compare (R4)
        high_mark = 32'd393216; low_mark = 32'd131072;
        step(32'd393216, 0, 16'hFFFF, 0, 1, 0);
        step(32'd131071, 0, 16'hFFFF, 0, 1, 0);
        step(32'd393217, 0, 16'h8000, 0, 1, 0);
        step(32'd131072, 0, 16'h8000, 0, 1, 0);
        step(32'hFFFF_FFFF, 0, 16'h0001, 1, 0, 0);
        chk("R4 unsigned max occupancy", {63'd0, status_word[27]}, 64'd1);
        step(32'd0, 1, 16'd0, 0, 1, 1);

        // R1: reset again after activity restores the flag
        @(negedge clk); rst_n = 0;
        m_low = 1; m_busy = 0; m_cmpl = 0; m_more = 0; m_irq = 0;
        @(posedge clk); @(negedge clk);
        chk("R1 re-reset word", status_word, 64'h0000_0000_1400_0000);
        rst_n = 1;

        done_flag = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule